// File: doc/BRIEF.md
# Decode-Stage Forwarding and Stall Unit

This block is the hazard controller of a five-stage in-order pipeline. Each cycle it looks at the two source register numbers of the instruction in decode. It compares them with the destination numbers and write enables carried by the execute, memory and writeback stage registers. For each operand it produces a two-bit select code. That code steers a four-way multiplexer in front of the operand latch, so the forwarded value is captured at the end of decode.

When the instruction in execute is a load and an operand of the decode instruction needs that load's result, the block raises a hold. The hold freezes the PC and the instruction register, and the execute stage receives a bubble on the next cycle. After that single lost cycle the load sits in the memory stage and its data is forwarded from there.

A jump or taken branch resolved in decode raises a squash. The squash turns the instruction fetched behind the jump or branch into a void slot. While that slot sits in decode it forwards nothing, stalls nothing and redirects nothing.

Top module: `hz_forward_unit`

## Requirements
- R1: The operand select codes are 0 to take the register file value, 1 to take the result of the instruction in execute, 2 for the instruction in memory, and 3 for the instruction in writeback.
- R2: When more than one stage matches a source, the nearest producer wins: execute before memory before writeback.
- R3: A source register number of zero never matches any stage, so its select code is 0.
- R4: A stage matches only when its write enable is 1 and its destination number equals the source number.
- R5: `hold` is 1 exactly when `ex_is_load` is 1, the decode slot is not void, and at least one select code equals 1. It follows the current inputs in the same cycle.
- R6: `ex_bubble` is 0 after reset and equals the value `hold` had in the previous cycle.
- R7: `squash` is 1 when `dec_redirect` is 1, `hold` is 0 and the decode slot is not void. `dec_void` is 0 after reset and equals the value `squash` had in the previous cycle.
- R8: While `dec_void` is 1, both select codes are 0 and `hold` and `squash` are 0, whatever the decode inputs are.
- R9: A load result forwarded from the memory stage (select code 2) raises no hold, so a load followed directly by a dependent instruction costs exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src1 | input | 5 | First source register number of the decode instruction |
| dec_src2 | input | 5 | Second source register number of the decode instruction |
| ex_dst | input | 5 | Destination number held in the execute stage register |
| ex_wen | input | 1 | Register-write control of the execute stage |
| ex_is_load | input | 1 | Memory-read control of the execute stage |
| mem_dst | input | 5 | Destination number held in the memory stage register |
| mem_wen | input | 1 | Register-write control of the memory stage |
| wb_dst | input | 5 | Destination number held in the writeback stage register |
| wb_wen | input | 1 | Register-write control of the writeback stage |
| dec_redirect | input | 1 | Jump or taken branch resolved in decode |
| opnd1_sel | output | 2 | Select code for the first operand |
| opnd2_sel | output | 2 | Select code for the second operand |
| hold | output | 1 | Freeze PC and instruction register, inject bubble |
| squash | output | 1 | Void the instruction being fetched |
| ex_bubble | output | 1 | Execute stage holds a bubble this cycle |
| dec_void | output | 1 | Decode slot holds a squashed instruction this cycle |

## Verification
The bench builds the block with its default parameters: five-bit register numbers and the fixed three producer stages. With these values every register number, including the zero register, can be driven directly from the bench. Directed stage patterns cover single matches at each stage, ties that exercise the nearest-producer priority, and a zero source, along with destinations whose write enable is cleared. Multi-cycle sequences then show a load-use stall turning into a memory-stage forward, a redirect producing a void slot that ignores its own inputs, and a redirect blocked by a simultaneous stall.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

    // Operand source choice, ordered by distance of the producer
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } fwd_sel_e;

    // Producer stages compared against decode, nearest first
    localparam int NUM_PROD = 3;

    // Registered control state of the unit
    typedef struct packed {
        logic ex_bubble;
        logic dec_void;
    } hz_ctl_t;

endpackage

// File: rtl/hz_operand_sel.sv
`timescale 1ns/1ps
module hz_operand_sel #(
    parameter int REG_W    = 5,
    parameter int NUM_PROD = hz_pkg::NUM_PROD,
    localparam int SEL_W   = $clog2(NUM_PROD + 1)
) (
    input  logic [REG_W-1:0]                src,
    input  logic [NUM_PROD-1:0][REG_W-1:0]  prod_dst,
    input  logic [NUM_PROD-1:0]             prod_wen,
    input  logic                            slot_void,
    output logic [SEL_W-1:0]                sel
);

    logic [NUM_PROD-1:0] hit;
    logic                src_live;

    assign src_live = (src != '0) && !slot_void;

    // One comparator per producer stage
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_cmp
        assign hit[p] = src_live && prod_wen[p] && (prod_dst[p] == src);
    end

    // Walk from farthest to nearest so the nearest hit overwrites
    always_comb begin
        sel = '0;
        for (int p = NUM_PROD - 1; p >= 0; p--) begin
            if (hit[p]) begin
                sel = SEL_W'(p + 1);
            end
        end
    end

endmodule

// File: rtl/hz_load_stall.sv
`timescale 1ns/1ps
module hz_load_stall #(
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = 2
) (
    input  logic                          ex_is_load,
    input  logic                          slot_void,
    input  logic [NUM_SRC-1:0][SEL_W-1:0] sel,
    output logic                          stall
);

    logic [NUM_SRC-1:0] wants_ex;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_use
        assign wants_ex[s] = (sel[s] == SEL_W'(hz_pkg::SEL_EX));
    end

    assign stall = ex_is_load && !slot_void && (|wants_ex);

endmodule

// File: rtl/hz_ctl_regs.sv
`timescale 1ns/1ps
module hz_ctl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic squash,
    output logic ex_bubble_q,
    output logic dec_void_q
);

    import hz_pkg::*;

    hz_ctl_t ctl_d;
    hz_ctl_t ctl_q;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.ex_bubble = stall;
        ctl_d.dec_void  = squash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ex_bubble_q = ctl_q.ex_bubble;
    assign dec_void_q  = ctl_q.dec_void;

endmodule

// File: rtl/hz_forward_unit.sv
`timescale 1ns/1ps
module hz_forward_unit #(
    parameter int REG_W = 5,
    localparam int NUM_SRC  = 2,
    localparam int NUM_PROD = hz_pkg::NUM_PROD,
    localparam int SEL_W    = $clog2(NUM_PROD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dec_src1,
    input  logic [REG_W-1:0] dec_src2,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wen,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    input  logic             dec_redirect,
    output logic [SEL_W-1:0] opnd1_sel,
    output logic [SEL_W-1:0] opnd2_sel,
    output logic             hold,
    output logic             squash,
    output logic             ex_bubble,
    output logic             dec_void
);

    logic [NUM_SRC-1:0][REG_W-1:0]  src_vec;
    logic [NUM_SRC-1:0][SEL_W-1:0]  sel_vec;
    logic [NUM_PROD-1:0][REG_W-1:0] prod_dst;
    logic [NUM_PROD-1:0]            prod_wen;
    logic                           stall_w;

    // Producers indexed by distance: 0 execute, 1 memory, 2 writeback
    assign prod_dst = {wb_dst, mem_dst, ex_dst};
    assign prod_wen = {wb_wen, mem_wen, ex_wen};
    assign src_vec  = {dec_src2, dec_src1};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
        hz_operand_sel #(
            .REG_W    (REG_W),
            .NUM_PROD (NUM_PROD)
        ) u_sel (
            .src       (src_vec[s]),
            .prod_dst  (prod_dst),
            .prod_wen  (prod_wen),
            .slot_void (dec_void),
            .sel       (sel_vec[s])
        );
    end

    hz_load_stall #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_stall (
        .ex_is_load (ex_is_load),
        .slot_void  (dec_void),
        .sel        (sel_vec),
        .stall      (stall_w)
    );

    // A stalled branch waits; it redirects once the stall clears
    assign squash = dec_redirect && !stall_w && !dec_void;

    hz_ctl_regs u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall_w),
        .squash      (squash),
        .ex_bubble_q (ex_bubble),
        .dec_void_q  (dec_void)
    );

    assign opnd1_sel = sel_vec[0];
    assign opnd2_sel = sel_vec[1];
    assign hold      = stall_w;

endmodule

// File: rtl/hz_forward_unit_chk.sv
`timescale 1ns/1ps
module hz_forward_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] dec_src1,
    input logic [REG_W-1:0] dec_src2,
    input logic [REG_W-1:0] ex_dst,
    input logic             ex_wen,
    input logic             ex_is_load,
    input logic [1:0]       opnd1_sel,
    input logic [1:0]       opnd2_sel,
    input logic             hold,
    input logic             squash,
    input logic             ex_bubble,
    input logic             dec_void
);

    // R1 / R4: an execute-stage choice needs a live matching producer
    a_r4_ex_match_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd1_sel == 2'd1) |-> (ex_wen && (ex_dst == dec_src1)));
    a_r4_ex_match_src2: assert property (@(posedge clk) disable iff (!rst_n)
        (opnd2_sel == 2'd1) |-> (ex_wen && (ex_dst == dec_src2)));

    // R3: the zero register is never forwarded
    a_r3_zero_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src1 == '0) |-> (opnd1_sel == 2'd0));
    a_r3_zero_src2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src2 == '0) |-> (opnd2_sel == 2'd0));

    // R5: a hold needs a load in execute
    a_r5_hold_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ex_is_load);

    // R6: the bubble follows the hold by one cycle
    a_r6_bubble_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ex_bubble);
    a_r6_bubble_only_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> !ex_bubble);

    // R7: squash never coincides with a hold, void slot follows squash
    a_r7_no_squash_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !squash);
    a_r7_void_after_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> dec_void);

    // R8: a void decode slot is quiet
    a_r8_void_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dec_void |-> (opnd1_sel == 2'd0 && opnd2_sel == 2'd0 && !hold && !squash));

endmodule

bind hz_forward_unit hz_forward_unit_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_src1   (dec_src1),
    .dec_src2   (dec_src2),
    .ex_dst     (ex_dst),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .opnd1_sel  (opnd1_sel),
    .opnd2_sel  (opnd2_sel),
    .hold       (hold),
    .squash     (squash),
    .ex_bubble  (ex_bubble),
    .dec_void   (dec_void)
);

// File: tb/hz_forward_unit_bench.sv
`timescale 1ns/1ps
module hz_forward_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] dec_src1 = '0, dec_src2 = '0;
    logic [4:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic       ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic       dec_redirect = 1'b0;
    logic [1:0] opnd1_sel, opnd2_sel;
    logic       hold, squash, ex_bubble, dec_void;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hz_forward_unit u_hz_forward_unit (
        .clk (clk), .rst_n (rst_n),
        .dec_src1 (dec_src1), .dec_src2 (dec_src2),
        .ex_dst (ex_dst), .ex_wen (ex_wen), .ex_is_load (ex_is_load),
        .mem_dst (mem_dst), .mem_wen (mem_wen),
        .wb_dst (wb_dst), .wb_wen (wb_wen),
        .dec_redirect (dec_redirect),
        .opnd1_sel (opnd1_sel), .opnd2_sel (opnd2_sel),
        .hold (hold), .squash (squash),
        .ex_bubble (ex_bubble), .dec_void (dec_void)
    );

    typedef struct {
        string      tag;
        logic [1:0] s1, s2;
        logic       hold, squash, bubble, void_slot;
    } exp_t;

    exp_t exp_q[$];
    logic prev_hold   = 1'b0;
    logic prev_squash = 1'b0;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference select from the requirements (R1..R4)
    function automatic logic [1:0] ref_sel(logic [4:0] s, logic vd);
        if (vd || s == 5'd0)                return 2'd0;
        if (ex_wen  && ex_dst  == s)        return 2'd1;
        if (mem_wen && mem_dst == s)        return 2'd2;
        if (wb_wen  && wb_dst  == s)        return 2'd3;
        return 2'd0;
    endfunction

    // Driver: apply one decode cycle and push its expectation
    task automatic step(string tag,
                        logic [4:0] s1, logic [4:0] s2,
                        logic [4:0] ed, logic ew, logic el,
                        logic [4:0] md, logic mw,
                        logic [4:0] wd, logic ww, logic rd);
        exp_t e;
        logic vd;
        @(negedge clk);
        dec_src1 = s1; dec_src2 = s2;
        ex_dst = ed; ex_wen = ew; ex_is_load = el;
        mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
        dec_redirect = rd;
        #0.5;
        vd          = prev_squash;
        e.tag       = tag;
        e.s1        = ref_sel(s1, vd);
        e.s2        = ref_sel(s2, vd);
        e.hold      = el && !vd && (e.s1 == 2'd1 || e.s2 == 2'd1);
        e.squash    = rd && !e.hold && !vd;
        e.bubble    = prev_hold;
        e.void_slot = prev_squash;
        prev_hold   = e.hold;
        prev_squash = e.squash;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs in the middle of the low phase
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check({e.tag, " opnd1_sel"}, opnd1_sel, e.s1);
                check({e.tag, " opnd2_sel"}, opnd2_sel, e.s2);
                check({e.tag, " hold R5"},   hold,      e.hold);
                check({e.tag, " squash R7"}, squash,    e.squash);
                check({e.tag, " ex_bubble R6"}, ex_bubble, e.bubble);
                check({e.tag, " dec_void R7"},  dec_void,  e.void_slot);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state of the registered outputs (R6, R7)
        check("R6 reset ex_bubble", ex_bubble, 0);
        check("R7 reset dec_void",  dec_void,  0);
        rst_n = 1'b1;

        //     tag   s1 s2  exd ew el  md mw  wd ww rd
        step("R1 idle",     5'd0, 5'd0, 5'd0, 0,0, 5'd0,0, 5'd0,0, 0);
        step("R1 ex+mem",   5'd5, 5'd7, 5'd5, 1,0, 5'd7,1, 5'd9,1, 0);
        step("R1 wb",       5'd9, 5'd3, 5'd5, 1,0, 5'd7,1, 5'd9,1, 0);
        step("R2 all",      5'd4, 5'd4, 5'd4, 1,0, 5'd4,1, 5'd4,1, 0);
        step("R2 mem+wb",   5'd4, 5'd4, 5'd4, 0,0, 5'd4,1, 5'd4,1, 0);
        step("R2 wb only",  5'd6, 5'd8, 5'd1, 1,0, 5'd8,1, 5'd6,1, 0);
        step("R3 zero src", 5'd0, 5'd0, 5'd0, 1,0, 5'd0,1, 5'd0,1, 0);
        step("R4 no wen",   5'd12,5'd13,5'd12,0,0, 5'd13,0,5'd12,0, 0);
        step("R4 mismatch", 5'd12,5'd13,5'd11,1,0, 5'd14,1,5'd15,1, 0);
        // R5 load-use on operand 1, then R9 forward from memory
        step("R5 load use1",5'd10,5'd2, 5'd10,1,1, 5'd3,1, 5'd4,1, 0);
        step("R9 mem fwd",  5'd10,5'd2, 5'd0, 0,0, 5'd10,1,5'd3,1, 0);
        step("R6 no stall", 5'd1, 5'd2, 5'd3, 1,0, 5'd4,1, 5'd5,1, 0);
        // R5 load-use on operand 2
        step("R5 load use2",5'd1, 5'd20,5'd20,1,1, 5'd21,1,5'd22,1,0);
        // R9 load in execute but dependency only on memory
        step("R9 no hold",  5'd21,5'd0, 5'd20,1,1, 5'd21,1,5'd22,1,0);
        // R5 load in execute writing the zero register
        step("R5 zero ld",  5'd0, 5'd0, 5'd0, 1,1, 5'd0,0, 5'd0,0, 0);
        // R7 redirect, R8 void slot ignores everything
        step("R7 redirect", 5'd1, 5'd2, 5'd3, 1,0, 5'd4,1, 5'd5,1, 1);
        step("R8 void",     5'd3, 5'd4, 5'd3, 1,1, 5'd4,1, 5'd5,1, 1);
        step("R8 after",    5'd3, 5'd5, 5'd3, 1,0, 5'd4,1, 5'd5,1, 0);
        // R7 redirect blocked by a hold, then taken once clear
        step("R7 blocked",  5'd7, 5'd0, 5'd7, 1,1, 5'd0,0, 5'd0,0, 1);
        step("R7 retry",    5'd7, 5'd0, 5'd0, 0,0, 5'd7,1, 5'd0,0, 1);
        step("R8 void2",    5'd7, 5'd7, 5'd7, 1,0, 5'd7,1, 5'd7,1, 0);
        step("R6 tail",     5'd0, 5'd0, 5'd0, 0,0, 5'd0,0, 5'd0,0, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule